// File: doc/BRIEF.md
# PCM Receive Deserializer with Timeslot Mapping

This block turns one serial PCM receive link into bytes. It watches a bit clock, a frame sync and a serial data line, all already brought into the system clock domain. It counts bit positions within a 256-bit frame of 32 eight-bit timeslots. A byte is handed on only when its timeslot carries payload under the selected mapping. Each delivered byte comes with a one-cycle strobe, its position in the frame and its payload channel number, which counts from zero.

Three mappings are available. The E1 mapping delivers thirty channels. The T1 mappings deliver either the low twenty-four timeslots or three out of every four timeslots. Either T1 mapping can also hold back the twenty-fourth channel for signaling, so that twenty-three remain. The active edge of the bit clock and the active level of the sync are each selectable. A checker polices the sync period. A sync that lands away from the frame boundary raises a sticky flag and the frame count restarts from that sync. When the unit is disabled, the byte outputs float and framing is lost.

Top module: `pcm_rx_deser`

## Requirements
- R1: After reset `out_valid` is 0 and `sync_err` is 0, and no byte is delivered until a sync has been seen.
- R2: Bits are shifted in MSB first on each active bit-clock edge. A sync marks bit 0 of timeslot 0. A frame is 256 bits long. After the eighth bit of a payload slot, `out_valid` is high for exactly one system cycle and carries that byte, `out_slot` (frame slot 0..31) and `out_chan`.
- R3: Mode code 0 (E1) delivers slots 1..15 and 17..31 and never delivers slots 0 and 16. Slots 1..15 are channels 0..14 and slots 17..31 are channels 15..29.
- R4: Mode code 1 (T1, low block) delivers slots 0..23, with channel equal to slot.
- R5: Mode code 2 (T1, three of four) skips every slot whose index modulo 4 is 3. The channel is slot minus slot/4, using integer division.
- R6: With `cfg_drop_ts24` set, mode codes 1 and 2 do not deliver channel 23 (slot 23 or slot 30), leaving 23 channels. The bit has no effect in mode code 0.
- R7: Mode code 3 delivers no bytes.
- R8: With `cfg_clk_inv` = 0, data is sampled on the rising bit-clock edge; with 1, on the falling edge. With `cfg_sync_inv` = 0 the sync is active high; with 1, active low.
- R9: The first sync after reset or enable is accepted silently. A sync exactly 256 bits after the frame start, or a missing sync, raises no error, and counting continues. A sync at any other bit sets `sync_err`, and counting restarts from that sync.
- R10: `sync_err` stays set until `err_clr` is high for a cycle. If a misplaced sync and `err_clr` fall in the same cycle, the flag ends up set.
- R11: While `en` is 0, `out_valid`, `out_byte`, `out_slot` and `out_chan` are high impedance. After re-enable, no byte is delivered until a new sync arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Unit enable |
| cfg_mode | input | 2 | Mapping: 0 E1, 1 T1 low 24, 2 T1 three of four, 3 none |
| cfg_drop_ts24 | input | 1 | Hold back T1 channel 23 |
| cfg_clk_inv | input | 1 | Sample on falling bit-clock edge |
| cfg_sync_inv | input | 1 | Sync active low |
| pcm_clk | input | 1 | Serial bit clock (synchronous to clk) |
| pcm_sync | input | 1 | Frame sync |
| pcm_data | input | 1 | Serial data |
| err_clr | input | 1 | Write-one clear of sync_err |
| out_valid | output | 1 | Byte strobe (tri-state) |
| out_byte | output | 8 | Received byte (tri-state) |
| out_slot | output | 5 | Frame slot of the byte (tri-state) |
| out_chan | output | 5 | Payload channel of the byte (tri-state) |
| sync_err | output | 1 | Sticky misplaced-sync flag |

## Verification
Two events can land on the same system cycle: the bit tick that carries a misplaced sync, and a software clear of the error flag. The bench raises `err_clr` in the very cycle whose active bit-clock edge carries a sync at bit 100 of a frame. It then expects the flag to read set, and a later lone clear must read zero. A realign also happens on the same tick as the start of a new byte. The scoreboard then expects the bytes that follow to be framed from the new sync.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;

    localparam int SLOT_BITS   = 8;
    localparam int FRAME_SLOTS = 32;
    localparam int FRAME_BITS  = SLOT_BITS * FRAME_SLOTS;
    localparam int CNT_W       = $clog2(FRAME_BITS);
    localparam int SLOT_W      = $clog2(FRAME_SLOTS);
    localparam int BIT_W       = $clog2(SLOT_BITS);
    localparam int E1_SKIP_HI  = FRAME_SLOTS / 2;
    localparam int T1_CHANS    = 24;
    localparam int T1_SIG_CHAN = T1_CHANS - 1;

    typedef enum logic [1:0] {
        MAP_E1       = 2'd0,
        MAP_T1_LOW24 = 2'd1,
        MAP_T1_3OF4  = 2'd2,
        MAP_NONE     = 2'd3
    } map_mode_e;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] chan;
    } slot_map_t;

    typedef struct packed {
        logic                 valid;
        logic [SLOT_BITS-1:0] data;
        logic [SLOT_W-1:0]    slot;
        logic [SLOT_W-1:0]    chan;
    } rx_out_t;

    function automatic slot_map_t map_slot(map_mode_e m, logic drop, int s);
        slot_map_t r;
        int        ch;
        r.hit = 1'b0;
        ch    = 0;
        case (m)
            MAP_E1: begin
                if (s != 0 && s != E1_SKIP_HI) begin
                    r.hit = 1'b1;
                    ch    = (s < E1_SKIP_HI) ? s - 1 : s - 2;
                end
            end
            MAP_T1_LOW24: begin
                if (s < T1_CHANS) begin
                    r.hit = 1'b1;
                    ch    = s;
                end
            end
            MAP_T1_3OF4: begin
                if ((s % 4) != 3) begin
                    r.hit = 1'b1;
                    ch    = s - (s / 4);
                end
            end
            default: r.hit = 1'b0;
        endcase
        if ((m == MAP_T1_LOW24 || m == MAP_T1_3OF4) && drop && ch == T1_SIG_CHAN)
            r.hit = 1'b0;
        r.chan = ch[SLOT_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/pcmrx_edge.sv
module pcmrx_edge (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clk_inv,
    input  logic sync_inv,
    input  logic pcm_clk,
    input  logic pcm_sync,
    input  logic pcm_data,
    output logic tick,
    output logic sync_act,
    output logic data_bit
);
    logic clk_norm;
    logic clk_prev;

    assign clk_norm = pcm_clk ^ clk_inv;

    always_ff @(posedge clk) begin
        if (rst) clk_prev <= 1'b1;
        else     clk_prev <= clk_norm;
    end

    assign tick     = en & clk_norm & ~clk_prev;
    assign sync_act = pcm_sync ^ sync_inv;
    assign data_bit = pcm_data;
endmodule

// File: rtl/pcmrx_framer.sv
module pcmrx_framer
    import pcmrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 tick,
    input  logic                 sync_act,
    input  logic                 data_bit,
    output logic                 byte_done,
    output logic [SLOT_BITS-1:0] byte_val,
    output logic [SLOT_W-1:0]    byte_slot,
    output logic                 misplaced
);
    logic [CNT_W-1:0]     bit_cnt;
    logic [CNT_W-1:0]     bit_idx;
    logic [SLOT_BITS-1:0] shreg;
    logic                 locked;
    logic                 lock_now;

    assign bit_idx   = sync_act ? '0 : bit_cnt;
    assign lock_now  = locked | sync_act;
    assign misplaced = tick & sync_act & locked & (bit_cnt != '0);
    assign byte_done = tick & lock_now & (&bit_idx[BIT_W-1:0]);
    assign byte_val  = {shreg[SLOT_BITS-2:0], data_bit};
    assign byte_slot = bit_idx[CNT_W-1:BIT_W];

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            bit_cnt <= '0;
            shreg   <= '0;
            locked  <= 1'b0;
        end else if (tick) begin
            shreg   <= byte_val;
            locked  <= lock_now;
            bit_cnt <= (bit_idx == CNT_W'(FRAME_BITS - 1)) ? '0 : bit_idx + 1'b1;
        end
    end
endmodule

// File: rtl/pcmrx_slotmap.sv
module pcmrx_slotmap
    import pcmrx_pkg::*;
(
    input  map_mode_e         mode,
    input  logic              drop,
    input  logic [SLOT_W-1:0] slot,
    output logic              hit,
    output logic [SLOT_W-1:0] chan
);
    slot_map_t tbl [FRAME_SLOTS];

    for (genvar g = 0; g < FRAME_SLOTS; g++) begin : g_slot
        assign tbl[g] = map_slot(mode, drop, g);
    end

    assign hit  = tbl[slot].hit;
    assign chan = tbl[slot].chan;
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
    import pcmrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [1:0]           cfg_mode,
    input  logic                 cfg_drop_ts24,
    input  logic                 cfg_clk_inv,
    input  logic                 cfg_sync_inv,
    input  logic                 pcm_clk,
    input  logic                 pcm_sync,
    input  logic                 pcm_data,
    input  logic                 err_clr,
    output logic                 out_valid,
    output logic [SLOT_BITS-1:0] out_byte,
    output logic [SLOT_W-1:0]    out_slot,
    output logic [SLOT_W-1:0]    out_chan,
    output logic                 sync_err
);
    logic                 tick;
    logic                 sync_act;
    logic                 data_bit;
    logic                 byte_done;
    logic [SLOT_BITS-1:0] byte_val;
    logic [SLOT_W-1:0]    byte_slot;
    logic                 misplaced;
    logic                 map_hit;
    logic [SLOT_W-1:0]    map_chan;
    map_mode_e            mode;
    rx_out_t              oreg;

    assign mode = map_mode_e'(cfg_mode);

    pcmrx_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .clk_inv  (cfg_clk_inv),
        .sync_inv (cfg_sync_inv),
        .pcm_clk  (pcm_clk),
        .pcm_sync (pcm_sync),
        .pcm_data (pcm_data),
        .tick     (tick),
        .sync_act (sync_act),
        .data_bit (data_bit)
    );

    pcmrx_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .tick      (tick),
        .sync_act  (sync_act),
        .data_bit  (data_bit),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .byte_slot (byte_slot),
        .misplaced (misplaced)
    );

    pcmrx_slotmap u_map (
        .mode (mode),
        .drop (cfg_drop_ts24),
        .slot (byte_slot),
        .hit  (map_hit),
        .chan (map_chan)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            oreg <= '0;
        end else begin
            oreg.valid <= byte_done & map_hit;
            if (byte_done) begin
                oreg.data <= byte_val;
                oreg.slot <= byte_slot;
                oreg.chan <= map_chan;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            sync_err <= 1'b0;
        else if (misplaced) sync_err <= 1'b1;
        else if (err_clr)   sync_err <= 1'b0;
    end

    assign out_valid = en ? oreg.valid : 1'bz;
    assign out_byte  = en ? oreg.data  : {SLOT_BITS{1'bz}};
    assign out_slot  = en ? oreg.slot  : {SLOT_W{1'bz}};
    assign out_chan  = en ? oreg.chan  : {SLOT_W{1'bz}};
endmodule

// File: rtl/pcm_rx_deser_chk.sv
module pcm_rx_deser_chk
    import pcmrx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [1:0]        cfg_mode,
    input logic              cfg_drop_ts24,
    input logic              err_clr,
    input logic              out_valid,
    input logic [SLOT_W-1:0] out_slot,
    input logic [SLOT_W-1:0] out_chan,
    input logic              sync_err
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst || !en)
        out_valid |=> !out_valid); // R2

    AST_E1_SKIPS: assert property (@(posedge clk) disable iff (rst || !en)
        (out_valid && $past(cfg_mode) == MAP_E1) |->
        (out_slot != 0 && out_slot != SLOT_W'(E1_SKIP_HI))); // R3

    AST_T1_LOW_RANGE: assert property (@(posedge clk) disable iff (rst || !en)
        (out_valid && $past(cfg_mode) == MAP_T1_LOW24) |->
        (out_slot < SLOT_W'(T1_CHANS) && out_chan == out_slot)); // R4

    AST_T1_3OF4_SKIP: assert property (@(posedge clk) disable iff (rst || !en)
        (out_valid && $past(cfg_mode) == MAP_T1_3OF4) |-> (out_slot[1:0] != 2'd3)); // R5

    AST_T1_DROP_SIG: assert property (@(posedge clk) disable iff (rst || !en)
        (out_valid && $past(cfg_drop_ts24) &&
         ($past(cfg_mode) == MAP_T1_LOW24 || $past(cfg_mode) == MAP_T1_3OF4)) |->
        (out_chan != SLOT_W'(T1_SIG_CHAN))); // R6

    AST_NONE_SILENT: assert property (@(posedge clk) disable iff (rst || !en)
        ($past(cfg_mode) == MAP_NONE) |-> !out_valid); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(sync_err) && !$past(err_clr)) |-> sync_err); // R10
endmodule

bind pcm_rx_deser pcm_rx_deser_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .cfg_mode      (cfg_mode),
    .cfg_drop_ts24 (cfg_drop_ts24),
    .err_clr       (err_clr),
    .out_valid     (out_valid),
    .out_slot      (out_slot),
    .out_chan      (out_chan),
    .sync_err      (sync_err)
);

// File: tb/pcm_rx_deser_tb_top.sv
module pcm_rx_deser_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic [1:0] cfg_mode = 2'd0;
    logic       cfg_drop_ts24 = 1'b0;
    logic       cfg_clk_inv = 1'b0;
    logic       cfg_sync_inv = 1'b0;
    logic       pcm_clk = 1'b0;
    logic       pcm_sync = 1'b0;
    logic       pcm_data = 1'b0;
    logic       err_clr = 1'b0;
    wire        out_valid;
    wire  [7:0] out_byte;
    wire  [4:0] out_slot;
    wire  [4:0] out_chan;
    wire        sync_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [17:0] expq [$];

    // model state
    int         m_cnt = 0;
    bit         m_locked = 0;
    bit         m_err = 0;
    logic [7:0] m_sh = 8'h00;

    always #5 clk = ~clk;

    pullup (out_valid);
    for (genvar i = 0; i < 8; i++) begin : g_pu_b
        pullup (out_byte[i]);
    end
    for (genvar i = 0; i < 5; i++) begin : g_pu_s
        pullup (out_slot[i]);
        pullup (out_chan[i]);
    end

    pcm_rx_deser dut_i (
        .clk(clk), .rst(rst), .en(en), .cfg_mode(cfg_mode),
        .cfg_drop_ts24(cfg_drop_ts24), .cfg_clk_inv(cfg_clk_inv),
        .cfg_sync_inv(cfg_sync_inv), .pcm_clk(pcm_clk), .pcm_sync(pcm_sync),
        .pcm_data(pcm_data), .err_clr(err_clr), .out_valid(out_valid),
        .out_byte(out_byte), .out_slot(out_slot), .out_chan(out_chan),
        .sync_err(sync_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // expected mapping from R3..R7
    task automatic exp_map(input int mode, input bit drop, input int s,
                           output bit hit, output int ch);
        hit = 0; ch = 0;
        if (mode == 0 && s != 0 && s != 16) begin hit = 1; ch = (s < 16) ? s - 1 : s - 2; end
        if (mode == 1 && s < 24) begin hit = 1; ch = s; end
        if (mode == 2 && (s % 4) != 3) begin hit = 1; ch = s - s / 4; end
        if ((mode == 1 || mode == 2) && drop && ch == 23) hit = 0;
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic send_bit(input bit b, input bit s, input bit clr);
        int idx; bit hit; int ch;
        if (s) begin
            if (m_locked && m_cnt != 0) m_err = 1;
            else if (clr) m_err = 0;
            idx = 0; m_locked = 1;
        end else begin
            idx = m_cnt;
            if (clr) m_err = 0;
        end
        m_sh = {m_sh[6:0], b};
        if (m_locked && (idx % 8) == 7) begin
            exp_map(cfg_mode, cfg_drop_ts24, idx / 8, hit, ch);
            if (hit) expq.push_back({m_sh, 5'(idx / 8), 5'(ch)});
        end
        m_cnt = (idx + 1) % 256;
        step();
        pcm_clk  = cfg_clk_inv;
        pcm_data = b;
        pcm_sync = s ^ cfg_sync_inv;
        step();
        pcm_clk = ~cfg_clk_inv;
        err_clr = clr;
        step();
        err_clr = 1'b0;
    endtask

    function automatic logic [7:0] gen(input int fr, input int s);
        return 8'(8'hA5 ^ (s * 13) ^ (fr * 7));
    endfunction

    task automatic send_frame(input bit with_sync, input int fr);
        for (int s = 0; s < 32; s++)
            for (int k = 7; k >= 0; k--) begin
                logic [7:0] v;
                v = gen(fr, s);
                send_bit(v[k], with_sync && s == 0 && k == 7, 1'b0);
            end
    endtask

    task automatic send_partial(input int nbits, input int fr);
        for (int i = 0; i < nbits; i++) begin
            logic [7:0] v;
            v = gen(fr, i / 8);
            send_bit(v[7 - (i % 8)], 1'b0, 1'b0);
        end
    endtask

    task automatic drain();
        repeat (4) step();
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && en) begin
            if (out_valid === 1'b1) begin
                if (expq.size() == 0) begin
                    check(0, "R2 unexpected byte", {out_byte, out_slot, out_chan}, 0);
                end else begin
                    logic [17:0] e;
                    logic [17:0] a;
                    e = expq.pop_front();
                    a = {out_byte, out_slot, out_chan};
                    check(a === e, "R2/R3-R7 byte,slot,chan", a, e);
                end
            end else if (out_valid !== 1'b0) begin
                check(0, "R2 strobe level", out_valid, 0);
            end
        end
    end

    initial begin
        #1_500_000;
        check(0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) step();
        check(out_valid === 1'b0, "R1 valid after reset", out_valid, 0);
        check(sync_err === 1'b0, "R1 err after reset", sync_err, 0);
        rst = 1'b0;
        step();

        // R1: no bytes before first sync
        send_partial(40, 9);
        drain();
        check(expq.size() == 0, "R1 nothing before sync", expq.size(), 0);

        // R3, R2: E1 frames, then R9 flywheel frame without sync
        cfg_mode = 2'd0;
        send_frame(1, 0);
        send_frame(1, 1);
        send_frame(0, 2);
        drain();
        check(sync_err === 1'b0, "R9 aligned/missing sync no error", sync_err, 0);
        check(expq.size() == 0, "R3 all E1 bytes seen", expq.size(), 0);

        // R6 no effect in E1
        cfg_drop_ts24 = 1'b1;
        send_frame(1, 3);
        // R4 and R6
        cfg_mode = 2'd1; cfg_drop_ts24 = 1'b0;
        send_frame(1, 4);
        cfg_drop_ts24 = 1'b1;
        send_frame(1, 5);
        // R5 and R6
        cfg_mode = 2'd2; cfg_drop_ts24 = 1'b0;
        send_frame(1, 6);
        cfg_drop_ts24 = 1'b1;
        send_frame(1, 7);
        // R7
        cfg_mode = 2'd3; cfg_drop_ts24 = 1'b0;
        send_frame(1, 8);
        drain();
        check(expq.size() == 0, "R4/R5/R6/R7 queue drained", expq.size(), 0);
        check(sync_err === 1'b0, "R9 no error on aligned syncs", sync_err, 0);

        // R9 misplaced sync then realigned framing
        cfg_mode = 2'd0;
        send_partial(100, 10);
        send_frame(1, 11);
        drain();
        check(sync_err === 1'b1, "R9 misplaced sync flagged", sync_err, 1);
        send_frame(1, 12);
        drain();
        check(sync_err === 1'b1, "R10 flag sticky", sync_err, 1);
        check(expq.size() == 0, "R9 realigned bytes", expq.size(), 0);

        // R10 clear alone
        err_clr = 1'b1; step(); err_clr = 1'b0; m_err = 0; step();
        check(sync_err === 1'b0, "R10 clear", sync_err, 0);

        // R10 set and clear in the same cycle
        send_partial(100, 13);
        send_bit(1'b1, 1'b1, 1'b1);
        drain();
        check(sync_err === m_err, "R10 set wins", sync_err, m_err);
        check(sync_err === 1'b1, "R10 set wins abs", sync_err, 1);
        err_clr = 1'b1; step(); err_clr = 1'b0; m_err = 0; step();
        check(sync_err === 1'b0, "R10 clear again", sync_err, 0);

        // R8 inverted clock and sync; resync at a fresh frame start
        send_partial(255, 14);
        cfg_clk_inv = 1'b1; cfg_sync_inv = 1'b1;
        pcm_clk = 1'b1; pcm_sync = 1'b1;
        step();
        send_frame(1, 15);
        send_frame(1, 16);
        drain();
        check(expq.size() == 0, "R8 inverted polarity bytes", expq.size(), 0);
        check(sync_err === 1'b0, "R8 no false sync error", sync_err, 0);

        // R11 disable
        en = 1'b0; m_locked = 0; m_cnt = 0; m_sh = 8'h00;
        step(); step();
        check(out_valid === 1'b1, "R11 valid floats (pulled up)", out_valid, 1);
        check(out_byte === 8'hFF, "R11 byte floats (pulled up)", out_byte, 8'hFF);
        check(out_slot === 5'h1F, "R11 slot floats (pulled up)", out_slot, 5'h1F);
        send_partial(16, 17);
        en = 1'b1;
        step();
        send_partial(40, 18);
        drain();
        check(expq.size() == 0, "R11 relock required", expq.size(), 0);
        send_frame(1, 19);
        drain();
        check(sync_err === 1'b0, "R9 first sync after enable accepted", sync_err, 0);
        check(expq.size() == 0, "R11 bytes after relock", expq.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule